// File: doc/BRIEF.md
# Quasi-Cyclic LDPC Parity Encoder (Dual-Diagonal Core, Diagonal Extension)

This block computes the parity of a quasi-cyclic LDPC codeword. It takes the information part as a run of Z-bit blocks, one block per clock. It returns the parity as Z-bit blocks: first the core parity blocks, then the extension parity blocks. The parity-check matrix has two parts. The core rows end in a dual-diagonal parity section. The extension rows end in an identity diagonal. Because of this, the parity comes from cyclic rotations and XOR accumulation alone. There is no matrix inversion and no generator-matrix multiply.

The lifting size is chosen per codeword, from 2 up to `ZMAX`. All storage and datapath widths are sized for `ZMAX`, so every smaller lifting size uses the same hardware. The circulant shift values of the base matrix sit in a small configuration memory, which is written through a simple write port. Each entry has two fields: a present flag and a shift amount. A start pulse begins a codeword. A done pulse follows the last parity block.

Top module: `ldpc_dd_enc`

## Requirements
- R1: While reset is active and in the cycle after it is released, `par_valid_o`, `done_o` and `par_o` are all zero.
- R2: A write with `cfg_we_i` high stores `cfg_data_i` at entry (row, col). The address is `cfg_addr_i = row*(KB+4) + col`. Bit `SHW` of the data is the present flag and bits `SHW-1:0` are the shift. An entry keeps its value across codewords until it is written again.
- R3: `start_i` is taken only when the block is idle, and it latches `z_i` at that moment. A start pulse during an encoding changes neither the lifting size nor the parity.
- R4: During the load phase, an information block is taken only in a cycle where `info_valid_i` is high. Exactly KB blocks are taken, and idle cycles between them are allowed. Data present while `info_valid_i` is low has no effect.
- R5: The first parity block is valid in the cycle after the edge that takes the last information block. After that, `par_valid_o` stays high for exactly 4+MEXT consecutive cycles: 4 core blocks, then MEXT extension blocks.
- R6: A block rotated by s has bit i equal to the source bit (i+s) mod z. The four core parity blocks p0..p3 zero every core row r. A core row sums its present information entries, each rotated by its shift. In the parity section, column 0 adds p0 unrotated in rows 0 and 3, and p0 rotated by d in row 1, where d is the shift field of entry (1, KB). For c = 1..3, column c adds pc unrotated in rows c-1 and c.
- R7: Each extension parity block e zeroes extension row 4+e. That row sums its present information entries and its present core-parity entries (columns KB..KB+3), each rotated by its shift, plus block e itself unrotated.
- R8: Bits z and above of `par_o` are zero whenever `par_valid_o` is high.
- R9: `done_o` is high for exactly one cycle, in the cycle right after the last valid parity block, and never together with `par_valid_o`.
- R10: An all-zero information word gives all-zero parity blocks, for any shift configuration.
- R11: Core-row entries in parity columns are ignored, with one exception: the shift field of entry (1, KB). Rewriting any of the other such entries leaves the parity unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_we_i | input | 1 | Configuration entry write enable |
| cfg_addr_i | input | AW | Entry address, row*(KB+4)+col |
| cfg_data_i | input | SHW+1 | {present flag, shift} |
| z_i | input | ZW | Lifting size, latched at start |
| start_i | input | 1 | Begin a codeword (taken when idle) |
| info_i | input | ZMAX | Information block |
| info_valid_i | input | 1 | Information block qualifier |
| par_o | output | ZMAX | Parity block |
| par_valid_o | output | 1 | Parity block qualifier |
| done_o | output | 1 | One-cycle end-of-codeword pulse |

## Verification
Each edge that takes an information block only updates the internal row accumulators, so no output moves during the load phase. The first parity block appears one cycle after the edge that takes the last information block. The remaining parity blocks follow on consecutive cycles, and `done_o` comes one cycle after the last of them. The bench starts a cycle counter at the negative edge after the last information block is driven. It then expects `par_valid_o` low at count 0, high for counts 1 through 4+MEXT, and `done_o` at count 5+MEXT. Parity values are checked after collection by computing every row syndrome from the bench's own copy of the configuration and requiring zero. The parity for a given matrix is unique, so a zero syndrome on every row means the values are correct.

// File: rtl/ldpc_enc_pkg.sv
// Shared constants and types for the dual-diagonal QC-LDPC encoder.
// Assumes the core parity section is always four block columns wide.
package ldpc_enc_pkg;
    localparam int CORE_N = 4;   // core parity block columns / core rows
    localparam int DD_ROW = 1;   // core row holding the rotated p0 entry

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CORE,
        ST_EXT
    } enc_state_e;
endpackage

// File: rtl/qc_rot.sv
// Cyclic rotation network for a runtime lifting size.
// Output bit i takes input bit (i+shift) mod z. Bits at and above z are zero.
// Assumes shift < z <= ZMAX. Input bits at and above z are never used.
module qc_rot #(
    parameter int ZMAX = 8,
    parameter int SHW  = 3,
    parameter int ZW   = 4
) (
    input  logic [ZMAX-1:0] din_i,
    input  logic [SHW-1:0]  shift_i,
    input  logic [ZW-1:0]   z_i,
    output logic [ZMAX-1:0] dout_o
);
    for (genvar i = 0; i < ZMAX; i++) begin : g_bit
        logic pick;
        // Pick the source bit for output position i.
        always_comb begin
            int src;
            src = i + int'(shift_i);
            if (src >= int'(z_i)) src = src - int'(z_i);
            pick = 1'b0;
            for (int j = 0; j < ZMAX; j++) begin
                if (j == src) pick = din_i[j];
            end
        end
        assign dout_o[i] = (i < int'(z_i)) ? pick : 1'b0;
    end
endmodule

// File: rtl/shift_cfg_mem.sv
// Register-based store for the base-matrix entries ({present, shift}).
// Reads a whole column (one entry per row) and one fixed entry at once.
// Writes to addresses outside NROW*NCOL are dropped.
module shift_cfg_mem #(
    parameter int NROW    = 8,
    parameter int NCOL    = 8,
    parameter int EW      = 4,
    parameter int AW      = 6,
    parameter int CLW     = 3,
    parameter int FIX_ROW = 1,
    parameter int FIX_COL = 4
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           we_i,
    input  logic [AW-1:0]  addr_i,
    input  logic [EW-1:0]  data_i,
    input  logic [CLW-1:0] col_i,
    output logic [EW-1:0]  col_o [NROW],
    output logic [EW-1:0]  fix_o
);
    logic [EW-1:0] mem_q [NROW][NCOL];

    // Entry storage: cleared by reset, written one entry at a time.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int r = 0; r < NROW; r++)
                for (int c = 0; c < NCOL; c++) mem_q[r][c] <= '0;
        end else if (we_i) begin
            for (int r = 0; r < NROW; r++)
                for (int c = 0; c < NCOL; c++)
                    if (addr_i == AW'(r * NCOL + c)) mem_q[r][c] <= data_i;
        end
    end

    // Column read: one entry per row for the selected column.
    always_comb begin
        for (int r = 0; r < NROW; r++) begin
            col_o[r] = '0;
            for (int c = 0; c < NCOL; c++)
                if (col_i == CLW'(c)) col_o[r] = mem_q[r][c];
        end
    end

    assign fix_o = mem_q[FIX_ROW][FIX_COL];
endmodule

// File: rtl/ldpc_dd_enc.sv
// QC-LDPC parity encoder with a dual-diagonal core and a diagonal extension.
// Load phase: KB info blocks are rotated and XORed into per-row accumulators.
// Core phase: emits p0 (total core sum rotated back by d), then p1..p3 by
//   recursion. Each core block is also folded into the extension rows.
// Ext phase: emits each extension accumulator in turn.
// Assumes 2 <= z <= ZMAX and that every configured shift is below z.
module ldpc_dd_enc
    import ldpc_enc_pkg::*;
#(
    parameter int ZMAX = 8,
    parameter int KB   = 4,
    parameter int MEXT = 4,
    localparam int NROW = CORE_N + MEXT,
    localparam int NCOL = KB + CORE_N,
    localparam int NPAR = CORE_N + MEXT,
    localparam int SHW  = $clog2(ZMAX),
    localparam int EW   = SHW + 1,
    localparam int ZW   = $clog2(ZMAX + 1),
    localparam int AW   = $clog2(NROW * NCOL),
    localparam int CLW  = $clog2(NCOL),
    localparam int CW   = $clog2(KB + NPAR + 1)
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            cfg_we_i,
    input  logic [AW-1:0]   cfg_addr_i,
    input  logic [EW-1:0]   cfg_data_i,
    input  logic [ZW-1:0]   z_i,
    input  logic            start_i,
    input  logic [ZMAX-1:0] info_i,
    input  logic            info_valid_i,
    output logic [ZMAX-1:0] par_o,
    output logic            par_valid_o,
    output logic            done_o
);
    enc_state_e      state_q;
    logic [CW-1:0]   cnt_q;
    logic [ZW-1:0]   z_q;
    logic [ZMAX-1:0] acc_q [NROW];
    logic [ZMAX-1:0] p0_q, p_prev_q;
    logic            fin_q;

    logic [CLW-1:0]  col_sel;
    logic [EW-1:0]   col_ent [NROW];
    logic [EW-1:0]   dd_ent;
    logic [SHW-1:0]  dd_sh, dd_inv;
    logic [ZMAX-1:0] rot_in, rot_out [NROW];
    logic [ZMAX-1:0] core_sum, p0_calc, p0_dd, prev_row, par_cur, ext_sel;

    assign col_sel = (state_q == ST_CORE) ? CLW'(KB) + CLW'(cnt_q) : CLW'(cnt_q);

    shift_cfg_mem #(
        .NROW(NROW), .NCOL(NCOL), .EW(EW), .AW(AW), .CLW(CLW),
        .FIX_ROW(DD_ROW), .FIX_COL(KB)
    ) u_mem (
        .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .data_i(cfg_data_i), .col_i(col_sel), .col_o(col_ent), .fix_o(dd_ent)
    );

    assign dd_sh  = dd_ent[SHW-1:0];
    assign dd_inv = (dd_sh == '0) ? '0 : SHW'(z_q - ZW'(dd_sh));
    assign rot_in = (state_q == ST_CORE) ? par_cur : info_i;

    // One rotator per matrix row, fed by info (load) or core parity (core).
    for (genvar r = 0; r < NROW; r++) begin : g_row_rot
        qc_rot #(.ZMAX(ZMAX), .SHW(SHW), .ZW(ZW)) u_rot (
            .din_i(rot_in), .shift_i(col_ent[r][SHW-1:0]), .z_i(z_q),
            .dout_o(rot_out[r])
        );
    end

    qc_rot #(.ZMAX(ZMAX), .SHW(SHW), .ZW(ZW)) u_rot_inv (
        .din_i(core_sum), .shift_i(dd_inv), .z_i(z_q), .dout_o(p0_calc)
    );
    qc_rot #(.ZMAX(ZMAX), .SHW(SHW), .ZW(ZW)) u_rot_dd (
        .din_i(p0_q), .shift_i(dd_sh), .z_i(z_q), .dout_o(p0_dd)
    );

    // Sum of all core-row accumulators (the parity columns cancel except p0).
    always_comb begin
        core_sum = '0;
        for (int r = 0; r < CORE_N; r++) core_sum = core_sum ^ acc_q[r];
    end

    // Core parity for the current step: p0 directly, later ones by recursion.
    always_comb begin
        prev_row = '0;
        for (int k = 0; k < CORE_N - 1; k++)
            if (cnt_q == CW'(k + 1)) prev_row = acc_q[k];
        if (cnt_q == '0) par_cur = p0_calc;
        else par_cur = prev_row ^ p_prev_q ^
                       ((cnt_q == CW'(DD_ROW + 1)) ? p0_dd : '0);
    end

    // Select the extension accumulator being emitted.
    always_comb begin
        ext_sel = '0;
        for (int e = 0; e < MEXT; e++)
            if (cnt_q == CW'(e)) ext_sel = acc_q[CORE_N + e];
    end

    // Phase sequencing, accumulation and registered outputs.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            cnt_q       <= '0;
            z_q         <= '0;
            p0_q        <= '0;
            p_prev_q    <= '0;
            fin_q       <= 1'b0;
            par_o       <= '0;
            par_valid_o <= 1'b0;
            done_o      <= 1'b0;
            for (int r = 0; r < NROW; r++) acc_q[r] <= '0;
        end else begin
            par_valid_o <= 1'b0;
            fin_q       <= 1'b0;
            done_o      <= fin_q;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_LOAD;
                    cnt_q   <= '0;
                    z_q     <= z_i;
                    for (int r = 0; r < NROW; r++) acc_q[r] <= '0;
                end
                ST_LOAD: if (info_valid_i) begin
                    for (int r = 0; r < NROW; r++)
                        if (col_ent[r][SHW]) acc_q[r] <= acc_q[r] ^ rot_out[r];
                    if (cnt_q == CW'(KB - 1)) begin
                        state_q <= ST_CORE;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_CORE: begin
                    par_o       <= par_cur;
                    par_valid_o <= 1'b1;
                    p_prev_q    <= par_cur;
                    if (cnt_q == '0) p0_q <= par_cur;
                    for (int e = 0; e < MEXT; e++)
                        if (col_ent[CORE_N + e][SHW])
                            acc_q[CORE_N + e] <= acc_q[CORE_N + e] ^ rot_out[CORE_N + e];
                    if (cnt_q == CW'(CORE_N - 1)) begin
                        state_q <= ST_EXT;
                        cnt_q   <= '0;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                ST_EXT: begin
                    par_o       <= ext_sel;
                    par_valid_o <= 1'b1;
                    if (cnt_q == CW'(MEXT - 1)) begin
                        state_q <= ST_IDLE;
                        fin_q   <= 1'b1;
                    end else cnt_q <= cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ldpc_dd_enc_chk.sv
// Protocol checker for ldpc_dd_enc, attached by bind.
// Counts valid parity blocks since the last done pulse and checks the
// framing and high-bit rules on the output side.
module ldpc_dd_enc_chk #(
    parameter int ZMAX = 8,
    parameter int NPAR = 8,
    parameter int ZW   = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [ZMAX-1:0] par_i,
    input logic            par_valid_i,
    input logic            done_i,
    input logic [ZW-1:0]   z_i
);
    logic [$clog2(NPAR+2)-1:0] run_q;

    // Valid blocks seen since the previous done pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) run_q <= '0;
        else if (done_i) run_q <= '0;
        else if (par_valid_i) run_q <= run_q + 1'b1;
    end

    AST_RUN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q <= ($clog2(NPAR+2))'(NPAR)); // R5
    AST_DONE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> run_q == ($clog2(NPAR+2))'(NPAR)); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |-> !par_valid_i && $past(par_valid_i)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_i |=> !done_i); // R9
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        par_valid_i |-> (par_i >> z_i) == '0); // R8
endmodule

bind ldpc_dd_enc ldpc_dd_enc_chk #(.ZMAX(ZMAX), .NPAR(NPAR), .ZW(ZW)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .par_i(par_o), .par_valid_i(par_valid_o),
    .done_i(done_o), .z_i(z_q)
);

// File: tb/ldpc_dd_enc_tb_top.sv
// Self-checking bench: a vector table of random configurations and words,
// followed by directed cases. Parity is judged by the row syndromes.
module ldpc_dd_enc_tb_top;
    localparam int CLK_P = 10;
    localparam int ZMAX = 8, KB = 4, MEXT = 4, CORE = 4;
    localparam int NROW = CORE + MEXT, NCOL = KB + CORE, NPAR = CORE + MEXT;
    localparam int SHW = $clog2(ZMAX), EW = SHW + 1, ZW = $clog2(ZMAX + 1);
    localparam int AW = $clog2(NROW * NCOL);

    typedef struct packed {
        logic [3:0]  z;
        logic [2:0]  dd;
        logic        gaps;
        logic        mid_start;
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{z: 4'd8, dd: 3'd1, gaps: 1'b0, mid_start: 1'b0, seed: 32'h0000_1234},
        '{z: 4'd5, dd: 3'd3, gaps: 1'b1, mid_start: 1'b0, seed: 32'h00AB_CDEF},
        '{z: 4'd3, dd: 3'd0, gaps: 1'b0, mid_start: 1'b1, seed: 32'h5A5A_0F0F},
        '{z: 4'd7, dd: 3'd6, gaps: 1'b1, mid_start: 1'b1, seed: 32'h1357_9BDF},
        '{z: 4'd2, dd: 3'd1, gaps: 1'b0, mid_start: 1'b0, seed: 32'hDEAD_0001},
        '{z: 4'd8, dd: 3'd7, gaps: 1'b1, mid_start: 1'b0, seed: 32'h0BAD_F00D}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, start = 1'b0, info_valid = 1'b0;
    logic [AW-1:0]   cfg_addr = '0;
    logic [EW-1:0]   cfg_data = '0;
    logic [ZW-1:0]   z_in = '0;
    logic [ZMAX-1:0] info = '0;
    logic [ZMAX-1:0] par;
    logic par_valid, done;

    int checks = 0, errors = 0;
    logic [31:0] st;
    logic            ep [NROW][NCOL];
    logic [SHW-1:0]  es [NROW][NCOL];
    int              dd_b;
    logic [ZMAX-1:0] info_blk [KB];
    logic [ZMAX-1:0] got [NPAR];
    logic [ZMAX-1:0] ref_par [NPAR];

    ldpc_dd_enc #(.ZMAX(ZMAX), .KB(KB), .MEXT(MEXT)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .cfg_data_i(cfg_data), .z_i(z_in), .start_i(start), .info_i(info),
        .info_valid_i(info_valid), .par_o(par), .par_valid_o(par_valid),
        .done_o(done)
    );

    always #(CLK_P / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] x);
        return x * 32'd1664525 + 32'd1013904223;
    endfunction

    function automatic logic [ZMAX-1:0] brot(input logic [ZMAX-1:0] x, input int s,
                                             input int z);
        logic [ZMAX-1:0] y = '0;
        for (int i = 0; i < z; i++) y[i] = x[(i + s) % z];
        return y;
    endfunction

    task automatic cfg_write(input int r, input int c, input logic p, input int s);
        cfg_we = 1'b1;
        cfg_addr = AW'(r * NCOL + c);
        cfg_data = {p, SHW'(s)};
        ep[r][c] = p;
        es[r][c] = SHW'(s);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_cfg(input int z, input int dd);
        for (int r = 0; r < NROW; r++)
            for (int c = 0; c < NCOL; c++) begin
                st = lcg(st);
                cfg_write(r, c, st[16], int'(st[15:8]) % z);
            end
        dd_b = dd % z;
        cfg_write(1, KB, 1'b1, dd_b);
    endtask

    // Run one codeword and check its framing (R5, R9) and high bits (R8).
    task automatic run_frame(input int z, input bit gaps, input bit mid);
        int first = -1, nv = 0, donek = -1;
        start = 1'b1; z_in = ZW'(z);
        @(negedge clk);
        start = 1'b0; z_in = ZW'((z % ZMAX) + 1);
        for (int j = 0; j < KB; j++) begin
            if (gaps) begin
                info_valid = 1'b0; info = ~info_blk[j] ^ ZMAX'(j * 37);
                @(negedge clk);
            end
            if (mid && j == 1) start = 1'b1;   // R3: ignored while busy
            info = info_blk[j]; info_valid = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        info_valid = 1'b0; info = 8'hA5;
        chk(par_valid == 1'b0, "R5 no output at edge taking last block", 64'(par_valid), 0);
        for (int k = 1; k <= NPAR + 2; k++) begin
            @(negedge clk);
            if (par_valid) begin
                if (first < 0) first = k;
                if (nv < NPAR) got[nv] = par;
                nv++;
            end
            if (done && donek < 0) donek = k;
        end
        chk(first == 1, "R5 first parity latency", 64'(first), 1);
        chk(nv == NPAR, "R5 parity block count", 64'(nv), 64'(NPAR));
        chk(donek == NPAR + 1, "R9 done timing", 64'(donek), 64'(NPAR + 1));
        for (int b = 0; b < NPAR; b++)
            chk((got[b] >> z) == '0, "R8 bits above z", 64'(got[b]), 0);
    endtask

    // Check every row syndrome of the collected codeword (R6 core, R7 ext).
    task automatic check_syn(input int z, input string tag);
        for (int r = 0; r < NROW; r++) begin
            logic [ZMAX-1:0] s = '0;
            for (int j = 0; j < KB; j++)
                if (ep[r][j]) s ^= brot(info_blk[j], int'(es[r][j]), z);
            if (r < CORE) begin
                if (r == 0 || r == 3) s ^= got[0];
                if (r == 1) s ^= brot(got[0], dd_b, z);
                for (int c = 1; c < CORE; c++)
                    if (r == c - 1 || r == c) s ^= got[c];
                chk(s == '0, $sformatf("R6 core syndrome row %0d %s", r, tag), 64'(s), 0);
            end else begin
                for (int c = 0; c < CORE; c++)
                    if (ep[r][KB + c]) s ^= brot(got[c], int'(es[r][KB + c]), z);
                s ^= got[r];
                chk(s == '0, $sformatf("R7 ext syndrome row %0d %s", r, tag), 64'(s), 0);
            end
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(par_valid == 0 && done == 0 && par == 0, "R1 outputs in reset",
            {par, par_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(par_valid == 0 && done == 0 && par == 0, "R1 outputs after release",
            {par, par_valid, done}, 0);

        // Vector table: configuration, word, framing and syndromes.
        foreach (VECS[v]) begin
            st = VECS[v].seed;
            load_cfg(int'(VECS[v].z), int'(VECS[v].dd));
            for (int j = 0; j < KB; j++) begin
                st = lcg(st);
                info_blk[j] = st[23:16];
            end
            run_frame(int'(VECS[v].z), VECS[v].gaps, VECS[v].mid_start);
            check_syn(int'(VECS[v].z), $sformatf("vec %0d (R2 R3 R4)", v));
        end

        // R2: same word again, no rewrite, identical parity.
        for (int b = 0; b < NPAR; b++) ref_par[b] = got[b];
        run_frame(8, 1'b0, 1'b0);
        for (int b = 0; b < NPAR; b++)
            chk(got[b] == ref_par[b], "R2 entries persist", 64'(got[b]), 64'(ref_par[b]));

        // R11: rewrite core-row parity-column entries other than (1,KB).
        for (int r = 0; r < CORE; r++)
            for (int c = KB; c < NCOL; c++)
                if (!(r == 1 && c == KB)) cfg_write(r, c, ~ep[r][c], (int'(es[r][c]) + 3) % 8);
        run_frame(8, 1'b0, 1'b0);
        for (int b = 0; b < NPAR; b++)
            chk(got[b] == ref_par[b], "R11 unused entries ignored", 64'(got[b]), 64'(ref_par[b]));

        // R10: all-zero word gives all-zero parity.
        for (int j = 0; j < KB; j++) info_blk[j] = '0;
        run_frame(6, 1'b1, 1'b0);
        for (int b = 0; b < NPAR; b++)
            chk(got[b] == '0, "R10 zero word", 64'(got[b]), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule